// File: doc/BRIEF.md
# Outbound Address Window Translator

This block converts a 36-bit address from the on-chip interconnect into a 44-bit address on an external bus. Software programs four numbered windows. Each window has a local base, a page-granular external target, an upper target extension, a size code, a transaction-type tag and an enable. A fifth register set acts as the fallback translation. An address that lands in no enabled numbered window is sent through the fallback set.

All four windows are compared with the request address in the same cycle. When several windows claim the address, the one with the smallest index is used. The chosen window's target bits replace the address bits above the window size. The bits below the window size pass through unchanged. The result, the window's type tag and the index of the window that was used appear one clock after the request.

A small register port writes and reads the window settings. A write takes effect on the next clock edge. A request sampled on the same edge as a write still sees the old settings.

Top module: `otw_unit`

## Requirements
- R1: After reset, numbered windows 0..3 are disabled, and their attribute registers read 0. The fallback set (index 4) reads attribute 0x8000_001F. All translation, extension and base registers read 0, and `rsp_valid` is 0.
- R2: Numbered window n claims an address when it is enabled and its size code s lies in 11..31. The window covers 2^(s+1) bytes. The address bits from position s+1 upward must equal the same bits of {base,12'h000}; base bits below the window size are ignored.
- R3: A numbered window whose size code is below 11 or above 31 never claims any address, even when it is enabled.
- R4: When several enabled windows claim an address, the lowest index wins. `rsp_win` reports that index, and `rsp_attr` is that window's type tag.
- R5: For a claiming window with size exponent k=s+1, `rsp_addr` is formed from two parts. Bits [k-1:0] come from the request address. Bits [43:k] come from {extension[11:0], translation[31:12], 12'h000}.
- R6: An address that no numbered window claims uses the fallback set. `rsp_win` is 4, `rsp_addr` is {fallback extension, request[31:0]}, `rsp_attr` is the fallback type tag, and the fallback translation register has no effect.
- R7: `rsp_valid` is `req_valid` delayed by exactly one clock. The response fields are registered with it.
- R8: Register writes take effect on the next clock. A request sampled on the same edge as a write is translated with the settings from before that write.
- R9: Register select codes: 0 is translation (data[31:12]), 1 is extension (data[11:0]), 2 is base (data[23:0] = local address bits [35:12]), 3 is attributes (enable data[31], type tag data[11:8], size code data[5:0]). `rd_data` appears one clock after `rd_win`/`rd_sel`. Unimplemented bits read 0.
- R10: Window indices 5..7 ignore writes and read 0. For index 4, base, size and enable writes are ignored. Index 4 reads base 0 and attributes with enable 1 and size 31.
- R11: The last byte of a window (base + 2^(s+1) - 1) is claimed by that window. The next byte is not.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request address is valid this cycle |
| req_addr | input | 36 | Local request address |
| wr_en | input | 1 | Register write strobe |
| wr_win | input | 3 | Window index for write (4 = fallback) |
| wr_sel | input | 2 | Register select for write |
| wr_data | input | 32 | Write data |
| rd_win | input | 3 | Window index for read |
| rd_sel | input | 2 | Register select for read |
| rd_data | output | 32 | Read data, one clock after the read address |
| rsp_valid | output | 1 | Response valid |
| rsp_addr | output | 44 | Translated external address |
| rsp_attr | output | 4 | Transaction-type tag of the selected window |
| rsp_win | output | 3 | Index of the selected window (4 = fallback) |

## Verification
The bound checker watches several properties on every cycle. It checks the one-clock valid delay and that the 4 KiB page offset always passes through. It checks that a fallback response carries the low 32 request bits, that a numbered window is reported only if it was enabled, and that the priority select is one-hot and drawn from the claiming windows. Some behaviours can only be shown by the bench's scenarios, because they depend on programmed settings. These are the exact window boundaries for each size code, the replacement of the upper bits, overlap ordering, rejection of illegal size codes, write/request ordering on the same edge, and the register layout on readback.

// File: rtl/otw_pkg.sv
package otw_pkg;
  // register select encoding on the write/read port
  typedef enum logic [1:0] {
    SEL_XLAT = 2'd0,
    SEL_XEXT = 2'd1,
    SEL_BASE = 2'd2,
    SEL_ATTR = 2'd3
  } reg_sel_e;

  // attribute register field positions
  localparam int ATTR_EN_BIT = 31;
  localparam int ATTR_TT_LSB = 8;
  localparam int ATTR_SZ_LSB = 0;
endpackage

// File: rtl/otw_regs.sv
module otw_regs
  import otw_pkg::*;
#(
  parameter int NUM_WIN = 4,
  parameter int LA_W    = 36,
  parameter int XA_W    = 44,
  parameter int LOW_W   = 32,
  parameter int PG_W    = 12,
  parameter int SZ_W    = 6,
  parameter int TT_W    = 4,
  parameter int DW      = 32,
  parameter int IDX_W   = 3,
  localparam int NREG   = NUM_WIN + 1,
  localparam int TA_W   = LOW_W - PG_W,
  localparam int TE_W   = XA_W - LOW_W,
  localparam int BA_W   = LA_W - PG_W
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          wr_en,
  input  logic [IDX_W-1:0]              wr_win,
  input  logic [1:0]                    wr_sel,
  input  logic [DW-1:0]                 wr_data,
  input  logic [IDX_W-1:0]              rd_win,
  input  logic [1:0]                    rd_sel,
  output logic [DW-1:0]                 rd_data,
  output logic [NREG-1:0][TA_W-1:0]     ta_q,
  output logic [NREG-1:0][TE_W-1:0]     te_q,
  output logic [NREG-1:0][TT_W-1:0]     tt_q,
  output logic [NUM_WIN-1:0][BA_W-1:0]  ba_q,
  output logic [NUM_WIN-1:0][SZ_W-1:0]  sz_q,
  output logic [NUM_WIN-1:0]            en_q
);
  localparam logic [SZ_W-1:0] SZ_FULL = SZ_W'(LOW_W - 1);

  reg_sel_e wsel, rsel;
  logic [DW-1:0] rd_next;

  assign wsel = reg_sel_e'(wr_sel);
  assign rsel = reg_sel_e'(rd_sel);

  always_ff @(posedge clk) begin
    if (rst) begin
      ta_q <= '0;
      te_q <= '0;
      tt_q <= '0;
      ba_q <= '0;
      sz_q <= '0;
      en_q <= '0;
    end else if (wr_en) begin
      for (int i = 0; i < NREG; i++) begin
        if (wr_win == IDX_W'(i)) begin
          case (wsel)
            SEL_XLAT: ta_q[i] <= wr_data[LOW_W-1:PG_W];
            SEL_XEXT: te_q[i] <= wr_data[TE_W-1:0];
            SEL_BASE: if (i < NUM_WIN) ba_q[i] <= wr_data[BA_W-1:0];
            SEL_ATTR: begin
              tt_q[i] <= wr_data[ATTR_TT_LSB +: TT_W];
              if (i < NUM_WIN) begin
                en_q[i] <= wr_data[ATTR_EN_BIT];
                sz_q[i] <= wr_data[ATTR_SZ_LSB +: SZ_W];
              end
            end
            default: ;
          endcase
        end
      end
    end
  end

  always_comb begin
    rd_next = '0;
    for (int i = 0; i < NREG; i++) begin
      if (rd_win == IDX_W'(i)) begin
        case (rsel)
          SEL_XLAT: rd_next[LOW_W-1:PG_W] = ta_q[i];
          SEL_XEXT: rd_next[TE_W-1:0]     = te_q[i];
          SEL_BASE: if (i < NUM_WIN) rd_next[BA_W-1:0] = ba_q[i];
          SEL_ATTR: begin
            rd_next[ATTR_TT_LSB +: TT_W] = tt_q[i];
            if (i < NUM_WIN) begin
              rd_next[ATTR_EN_BIT]          = en_q[i];
              rd_next[ATTR_SZ_LSB +: SZ_W]  = sz_q[i];
            end else begin
              rd_next[ATTR_EN_BIT]          = 1'b1;
              rd_next[ATTR_SZ_LSB +: SZ_W]  = SZ_FULL;
            end
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_next;
  end
endmodule

// File: rtl/otw_match.sv
module otw_match #(
  parameter int LA_W  = 36,
  parameter int XA_W  = 44,
  parameter int LOW_W = 32,
  parameter int PG_W  = 12,
  parameter int SZ_W  = 6,
  localparam int TA_W = LOW_W - PG_W,
  localparam int TE_W = XA_W - LOW_W,
  localparam int BA_W = LA_W - PG_W
) (
  input  logic [LA_W-1:0] addr,
  input  logic [BA_W-1:0] base,
  input  logic [TA_W-1:0] ta,
  input  logic [TE_W-1:0] te,
  input  logic [SZ_W-1:0] sz,
  input  logic            en,
  output logic            hit,
  output logic [XA_W-1:0] xaddr
);
  localparam int SZ_MIN = PG_W - 1;
  localparam int SZ_MAX = LOW_W - 1;

  logic [SZ_W:0]     k;
  logic              legal;
  logic [LA_W-1:0]   mask_l;
  logic [XA_W-1:0]   mask_x;

  always_comb begin
    k      = {1'b0, sz} + 1'b1;
    legal  = (int'(sz) >= SZ_MIN) && (int'(sz) <= SZ_MAX);
    mask_l = {LA_W{1'b1}} << k;
    mask_x = {XA_W{1'b1}} << k;
    hit    = en && legal &&
             (((addr ^ {base, {PG_W{1'b0}}}) & mask_l) == '0);
    xaddr  = ({te, ta, {PG_W{1'b0}}} & mask_x) |
             ({{(XA_W-LA_W){1'b0}}, addr} & ~mask_x);
  end
endmodule

// File: rtl/otw_prio.sv
module otw_prio #(
  parameter int NUM_WIN = 4,
  parameter int IDX_W   = 3
) (
  input  logic [NUM_WIN-1:0] hit_vec,
  output logic [NUM_WIN-1:0] sel_oh,
  output logic               any_hit,
  output logic [IDX_W-1:0]   sel_idx
);
  always_comb begin
    sel_oh  = '0;
    any_hit = 1'b0;
    sel_idx = IDX_W'(NUM_WIN);
    for (int i = 0; i < NUM_WIN; i++) begin
      if (hit_vec[i] && !any_hit) begin
        sel_oh[i] = 1'b1;
        any_hit   = 1'b1;
        sel_idx   = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/otw_unit.sv
module otw_unit #(
  parameter int NUM_WIN = 4,
  parameter int LA_W    = 36,
  parameter int XA_W    = 44,
  parameter int LOW_W   = 32,
  parameter int PG_W    = 12,
  parameter int SZ_W    = 6,
  parameter int TT_W    = 4,
  parameter int DW      = 32,
  parameter int IDX_W   = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic [LA_W-1:0]  req_addr,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_win,
  input  logic [1:0]       wr_sel,
  input  logic [DW-1:0]    wr_data,
  input  logic [IDX_W-1:0] rd_win,
  input  logic [1:0]       rd_sel,
  output logic [DW-1:0]    rd_data,
  output logic             rsp_valid,
  output logic [XA_W-1:0]  rsp_addr,
  output logic [TT_W-1:0]  rsp_attr,
  output logic [IDX_W-1:0] rsp_win
);
  localparam int NREG = NUM_WIN + 1;
  localparam int TA_W = LOW_W - PG_W;
  localparam int TE_W = XA_W - LOW_W;
  localparam int BA_W = LA_W - PG_W;

  logic [NREG-1:0][TA_W-1:0]     ta_q;
  logic [NREG-1:0][TE_W-1:0]     te_q;
  logic [NREG-1:0][TT_W-1:0]     tt_q;
  logic [NUM_WIN-1:0][BA_W-1:0]  ba_q;
  logic [NUM_WIN-1:0][SZ_W-1:0]  sz_q;
  logic [NUM_WIN-1:0]            win_en;
  logic [NUM_WIN-1:0]            hit_vec;
  logic [NUM_WIN-1:0]            sel_oh;
  logic [NUM_WIN-1:0][XA_W-1:0]  xw;
  logic                          any_hit;
  logic [IDX_W-1:0]              sel_idx;
  logic [XA_W-1:0]               xsel;
  logic [TT_W-1:0]               tsel;

  otw_regs #(
    .NUM_WIN(NUM_WIN), .LA_W(LA_W), .XA_W(XA_W), .LOW_W(LOW_W), .PG_W(PG_W),
    .SZ_W(SZ_W), .TT_W(TT_W), .DW(DW), .IDX_W(IDX_W)
  ) regs_i (
    .clk(clk), .rst(rst),
    .wr_en(wr_en), .wr_win(wr_win), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_win(rd_win), .rd_sel(rd_sel), .rd_data(rd_data),
    .ta_q(ta_q), .te_q(te_q), .tt_q(tt_q), .ba_q(ba_q), .sz_q(sz_q),
    .en_q(win_en)
  );

  for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
    otw_match #(
      .LA_W(LA_W), .XA_W(XA_W), .LOW_W(LOW_W), .PG_W(PG_W), .SZ_W(SZ_W)
    ) match_i (
      .addr(req_addr), .base(ba_q[g]), .ta(ta_q[g]), .te(te_q[g]),
      .sz(sz_q[g]), .en(win_en[g]), .hit(hit_vec[g]), .xaddr(xw[g])
    );
  end

  otw_prio #(.NUM_WIN(NUM_WIN), .IDX_W(IDX_W)) prio_i (
    .hit_vec(hit_vec), .sel_oh(sel_oh), .any_hit(any_hit), .sel_idx(sel_idx)
  );

  always_comb begin
    if (any_hit) begin
      xsel = '0;
      tsel = '0;
      for (int i = 0; i < NUM_WIN; i++) begin
        if (sel_oh[i]) begin
          xsel = xsel | xw[i];
          tsel = tsel | tt_q[i];
        end
      end
    end else begin
      xsel = {te_q[NUM_WIN], req_addr[LOW_W-1:0]};
      tsel = tt_q[NUM_WIN];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_addr  <= '0;
      rsp_attr  <= '0;
      rsp_win   <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_addr  <= xsel;
      rsp_attr  <= tsel;
      rsp_win   <= sel_idx;
    end
  end
endmodule

// File: rtl/otw_unit_chk.sv
module otw_unit_chk #(
  parameter int NUM_WIN = 4,
  parameter int LA_W    = 36,
  parameter int XA_W    = 44,
  parameter int LOW_W   = 32,
  parameter int PG_W    = 12,
  parameter int IDX_W   = 3
) (
  input logic               clk,
  input logic               rst,
  input logic               req_valid,
  input logic [LA_W-1:0]    req_addr,
  input logic               rsp_valid,
  input logic [XA_W-1:0]    rsp_addr,
  input logic [IDX_W-1:0]   rsp_win,
  input logic [NUM_WIN-1:0] win_en,
  input logic [NUM_WIN-1:0] hit_vec,
  input logic [NUM_WIN-1:0] sel_oh
);
  assert_valid_rise_R7: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);

  assert_valid_idle_R7: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid);

  assert_page_offset_R5: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> (rsp_addr[PG_W-1:0] == $past(req_addr[PG_W-1:0])));

  assert_fallback_low_R6: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_win == IDX_W'(NUM_WIN)) |->
      (rsp_addr[LOW_W-1:0] == $past(req_addr[LOW_W-1:0])));

  assert_win_range_R6: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> (int'(rsp_win) <= NUM_WIN));

  assert_hit_enabled_R2: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && int'(rsp_win) < NUM_WIN) |->
      (($past(win_en) >> rsp_win) & NUM_WIN'(1)) != '0);

  assert_sel_onehot_R4: assert property (@(posedge clk) disable iff (rst)
    $onehot0(sel_oh));

  assert_sel_from_hits_R4: assert property (@(posedge clk) disable iff (rst)
    ((sel_oh & ~hit_vec) == '0) && ((hit_vec != '0) == (sel_oh != '0)));
endmodule

bind otw_unit otw_unit_chk #(
  .NUM_WIN(NUM_WIN), .LA_W(LA_W), .XA_W(XA_W), .LOW_W(LOW_W),
  .PG_W(PG_W), .IDX_W(IDX_W)
) chk_i (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
  .rsp_valid(rsp_valid), .rsp_addr(rsp_addr), .rsp_win(rsp_win),
  .win_en(win_en), .hit_vec(hit_vec), .sel_oh(sel_oh)
);

// File: tb/otw_unit_tb_top.sv
module otw_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [35:0] req_addr = '0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_win = '0;
  logic [1:0]  wr_sel = '0;
  logic [31:0] wr_data = '0;
  logic [2:0]  rd_win = '0;
  logic [1:0]  rd_sel = '0;
  logic [31:0] rd_data;
  logic        rsp_valid;
  logic [43:0] rsp_addr;
  logic [3:0]  rsp_attr;
  logic [2:0]  rsp_win;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  // bench shadow of programmed settings
  logic [19:0] m_ta [5];
  logic [11:0] m_te [5];
  logic [3:0]  m_tt [5];
  logic [23:0] m_ba [4];
  logic [5:0]  m_sz [4];
  logic        m_en [4];

  always #4 clk = ~clk;

  otw_unit dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .wr_en(wr_en), .wr_win(wr_win), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_win(rd_win), .rd_sel(rd_sel), .rd_data(rd_data),
    .rsp_valid(rsp_valid), .rsp_addr(rsp_addr), .rsp_attr(rsp_attr),
    .rsp_win(rsp_win)
  );

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  task automatic chk(input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  task automatic model(input logic [35:0] a, output logic [43:0] o,
                       output logic [2:0] w, output logic [3:0] t);
    logic [63:0] a64, mask, b64, x64;
    int k;
    a64 = {28'd0, a};
    w = 3'd4;
    o = {m_te[4], a[31:0]};
    t = m_tt[4];
    for (int n = 3; n >= 0; n--) begin
      if (m_en[n] && m_sz[n] >= 6'd11 && m_sz[n] <= 6'd31) begin
        k = int'(m_sz[n]) + 1;
        mask = (64'd1 << k) - 64'd1;
        b64 = {28'd0, m_ba[n], 12'd0};
        if (((a64 ^ b64) & ~mask) == 64'd0) begin
          x64 = {20'd0, m_te[n], m_ta[n], 12'd0};
          o = 44'((x64 & ~mask) | (a64 & mask));
          w = 3'(n);
          t = m_tt[n];
        end
      end
    end
  endtask

  task automatic shadow_wr(input logic [2:0] w, input logic [1:0] s,
                           input logic [31:0] d);
    if (w <= 3'd4) begin
      case (s)
        2'd0: m_ta[w] = d[31:12];
        2'd1: m_te[w] = d[11:0];
        2'd2: if (w < 3'd4) m_ba[w[1:0]] = d[23:0];
        default: begin
          m_tt[w] = d[11:8];
          if (w < 3'd4) begin
            m_en[w[1:0]] = d[31];
            m_sz[w[1:0]] = d[5:0];
          end
        end
      endcase
    end
  endtask

  task automatic wr(input logic [2:0] w, input logic [1:0] s,
                    input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_win = w; wr_sel = s; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    shadow_wr(w, s, d);
  endtask

  task automatic rd_chk(input logic [2:0] w, input logic [1:0] s,
                        input logic [31:0] exp, input string tag);
    @(negedge clk);
    rd_win = w; rd_sel = s;
    @(negedge clk);
    chk(tag, "rd_data", {32'd0, rd_data}, {32'd0, exp});
  endtask

  task automatic do_req(input logic [35:0] a, input string tag);
    logic [43:0] eo; logic [2:0] ew; logic [3:0] et;
    model(a, eo, ew, et);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R7", "rsp_valid", {63'd0, rsp_valid}, 64'd1);
    chk(tag, "rsp_addr", {20'd0, rsp_addr}, {20'd0, eo});
    chk(tag, "rsp_win", {61'd0, rsp_win}, {61'd0, ew});
    chk(tag, "rsp_attr", {60'd0, rsp_attr}, {60'd0, et});
  endtask

  task automatic clear_all();
    for (int n = 0; n < 4; n++) wr(3'(n), 2'd3, 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [35:0] base;
    logic [63:0] bytes;
    int k;
    for (int i = 0; i < 5; i++) begin m_ta[i] = '0; m_te[i] = '0; m_tt[i] = '0; end
    for (int i = 0; i < 4; i++) begin m_ba[i] = '0; m_sz[i] = '0; m_en[i] = 1'b0; end

    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", "rsp_valid in reset", {63'd0, rsp_valid}, 64'd0);
    rst = 1'b0;

    // R1 reset state
    for (int n = 0; n < 4; n++) rd_chk(3'(n), 2'd3, 32'd0, "R1");
    rd_chk(3'd4, 2'd3, 32'h8000_001F, "R1");
    for (int n = 0; n < 5; n++) begin
      rd_chk(3'(n), 2'd0, 32'd0, "R1");
      rd_chk(3'(n), 2'd1, 32'd0, "R1");
      rd_chk(3'(n), 2'd2, 32'd0, "R1");
    end
    do_req(36'hF_1234_5678, "R1");
    chk("R1", "fallback addr after reset", {20'd0, rsp_addr}, 64'h0000_1234_5678);

    // R7 idle cycle keeps valid low
    @(negedge clk);
    chk("R7", "rsp_valid idle", {63'd0, rsp_valid}, 64'd0);

    // R6 fallback settings; translation register has no effect
    wr(3'd4, 2'd0, 32'hFFFF_F000);
    wr(3'd4, 2'd1, 32'h0000_0ABC);
    wr(3'd4, 2'd3, 32'h0000_0700);
    do_req(36'h3_DEAD_BEEF, "R6");
    chk("R6", "fallback explicit", {20'd0, rsp_addr}, 64'h0ABC_DEAD_BEEF);

    // R9 / R10 readback and layout
    rd_chk(3'd4, 2'd0, 32'hFFFF_F000, "R9");
    rd_chk(3'd4, 2'd1, 32'h0000_0ABC, "R9");
    rd_chk(3'd4, 2'd3, 32'h8000_071F, "R10");
    wr(3'd4, 2'd2, 32'h00AB_CDEF);
    rd_chk(3'd4, 2'd2, 32'd0, "R10");
    wr(3'd5, 2'd0, 32'h1234_5000);
    rd_chk(3'd5, 2'd0, 32'd0, "R10");
    wr(3'd7, 2'd3, 32'hFFFF_FFFF);
    rd_chk(3'd7, 2'd3, 32'd0, "R10");
    rd_chk(3'd4, 2'd0, 32'hFFFF_F000, "R10");
    wr(3'd2, 2'd3, 32'hFFFF_FFFF);
    rd_chk(3'd2, 2'd3, 32'h8000_0F3F, "R9");
    wr(3'd2, 2'd2, 32'hFFFF_FFFF);
    rd_chk(3'd2, 2'd2, 32'h00FF_FFFF, "R9");
    clear_all();

    // R2 R5 R11 sweep each window over size codes
    for (int n = 0; n < 4; n++) begin
      for (int si = 0; si < 6; si++) begin
        logic [5:0] sc;
        case (si)
          0: sc = 6'd11; 1: sc = 6'd12; 2: sc = 6'd17;
          3: sc = 6'd23; 4: sc = 6'd28; default: sc = 6'd31;
        endcase
        k = int'(sc) + 1;
        bytes = 64'd1 << k;
        base = 36'((64'h9_A5C3_7000 >> k) << k);
        clear_all();
        wr(3'(n), 2'd2, {8'd0, base[35:12]});
        wr(3'(n), 2'd0, 32'hC35A_B000 ^ (32'(n) << 20));
        wr(3'(n), 2'd1, 32'h5A0 + 32'(n));
        wr(3'(n), 2'd3, 32'h8000_0000 | (32'(n + 1) << 8) | 32'(sc));
        do_req(base, "R2");
        do_req(36'(base + bytes - 1), "R11");
        do_req(36'(base + bytes), "R11");
        do_req(36'(base - 1), "R11");
        do_req(36'(base + (bytes >> 1) + 64'h3A7), "R5");
      end
    end

    // R3 illegal size codes never match
    clear_all();
    wr(3'd1, 2'd2, 32'h0000_1234);
    for (int si = 0; si < 4; si++) begin
      logic [5:0] sc;
      case (si) 0: sc = 6'd5; 1: sc = 6'd10; 2: sc = 6'd32; default: sc = 6'd63; endcase
      wr(3'd1, 2'd3, 32'h8000_0200 | 32'(sc));
      do_req(36'h0_0123_4000, "R3");
      chk("R3", "win fallback", {61'd0, rsp_win}, 64'd4);
    end

    // R4 overlap priority
    clear_all();
    for (int n = 0; n < 4; n++) begin
      wr(3'(n), 2'd2, 32'h0004_0000);
      wr(3'(n), 2'd0, 32'(n + 1) << 28);
      wr(3'(n), 2'd1, 32'(n + 8));
    end
    wr(3'd0, 2'd3, 32'h8000_010C);
    wr(3'd1, 2'd3, 32'h8000_0214);
    wr(3'd2, 2'd3, 32'h8000_031F);
    wr(3'd3, 2'd3, 32'h8000_041F);
    do_req(36'h0_4000_0100, "R4");
    chk("R4", "win0 first", {61'd0, rsp_win}, 64'd0);
    do_req(36'h0_4000_4000, "R4");
    chk("R4", "win1 next", {61'd0, rsp_win}, 64'd1);
    do_req(36'h0_4030_0000, "R4");
    chk("R4", "win2 over win3", {61'd0, rsp_win}, 64'd2);
    wr(3'd0, 2'd3, 32'h0000_010C);
    do_req(36'h0_4000_0100, "R4");
    chk("R4", "win1 when win0 off", {61'd0, rsp_win}, 64'd1);
    wr(3'd2, 2'd3, 32'h0000_031F);
    do_req(36'h0_4030_0000, "R4");
    chk("R4", "win3 when win2 off", {61'd0, rsp_win}, 64'd3);

    // R8 write and request on same edge
    clear_all();
    wr(3'd0, 2'd2, 32'h0000_0800);
    @(negedge clk);
    wr_en = 1'b1; wr_win = 3'd0; wr_sel = 2'd3; wr_data = 32'h8000_050B;
    req_valid = 1'b1; req_addr = 36'h0_0080_0040;
    @(negedge clk);
    wr_en = 1'b0; req_valid = 1'b0;
    chk("R8", "old settings win", {61'd0, rsp_win}, 64'd4);
    chk("R8", "old settings addr", {20'd0, rsp_addr}, {20'd0, m_te[4], 32'h0080_0040});
    shadow_wr(3'd0, 2'd3, 32'h8000_050B);
    do_req(36'h0_0080_0040, "R8");
    chk("R8", "new settings win", {61'd0, rsp_win}, 64'd0);

    summary();
  end
endmodule